// File: doc/BRIEF.md
# Bus Cycle Sequencer

This block produces the external bus timing of an 8-bit processor with a 16-bit address bus. Instruction decode and execution live elsewhere. They hand the sequencer one machine-cycle request at a time: a kind code, an address and write data. The sequencer then walks the T-states of that cycle and drives the address bus, the data bus with its enable, and the strobes. All strobes are modelled active-high. When the cycle ends it raises a one-clock done pulse. For reads, the byte it captured is then on `rdata`.

The block runs from a clock at twice the T-state rate. Every T-state is two clocks long: a first half (`half`=0) and a second half (`half`=1). This lets strobes start or stop half a T-state into a state.

The cycle kinds are:
- **Opcode fetch.** Four T-states. The last two carry a 7-bit refresh address, and that counter advances after each fetch.
- **Memory read and memory write.** Three T-states each.
- **I/O read and I/O write.** These add one automatic wait state.

WAIT inserts further wait states. A bus request is honoured only at the end of a machine cycle, or while the sequencer is idle. The address, data and control outputs are then released (`bus_drive`=0, forced to 0 in this model) and `busack` is raised until the request goes away.

States:
- `ST_IDLE`: no cycle.
- `ST_T1`, `ST_T2`: first two T-states.
- `ST_TA`: automatic I/O wait.
- `ST_TW`: requested wait.
- `ST_T3`, `ST_T4`: last T-states.
- `ST_HOLD`: bus granted.

Each T-state moves on after its second half. The transitions are:
- IDLE→HOLD on busreq.
- IDLE→T1 on a legal request.
- T1→T2.
- T2→TA for I/O.
- T2/TA/TW→TW when the latched WAIT sample is high, otherwise →T3.
- T3→T4 for fetch.
- Last state→HOLD if busreq is high, else →IDLE.
- HOLD→IDLE when busreq is low.

Top module: `bus_seq`

## Requirements
- R1: A request is taken only in a clock where the sequencer is idle and `req_valid` is high. Legal kind codes are 0 fetch, 1 memory read, 2 memory write, 3 I/O read and 4 I/O write. Codes 5 to 7 start nothing. A request during a cycle or during a grant is ignored.
- R2: A fetch has T1, T2, any waits, T3 and T4.
  - `addr_out` holds the request address through T1, T2 and the waits.
  - `m1` is high over that same span.
  - `mreq` and `rd` are high from the second half of T1 through the last wait (or T2).
  - The byte on `data_in` is captured at the edge that starts T3.
- R3: In T3 and T4 of a fetch:
  - `rfsh` is high.
  - `rd` is low.
  - `addr_out` is the refresh count in bits 6..0, with zeros above.
  - `mreq` is high in the second half of T3 and the first half of T4.
- R4: The refresh count is 0 after reset. It increments by one after every fetch and wraps from 127 to 0.
- R5: A memory read is T1, T2, waits, T3. `mreq` and `rd` are high from the second half of T1 to the end of the first half of T3. Data is captured at the edge between T3's halves.
- R6: A memory write has the timing of a memory read, with these differences:
  - `wr` replaces `rd` and is high from the second half of T2 to the end of the first half of T3.
  - `data_oe` is high, with `data_out` equal to the write data, from the second half of T1 to the end of T3.
  - `rd` and `wr` are never high together.
- R7: An I/O cycle is T1, T2, one automatic wait TA, any further waits, then T3. `mreq` stays low throughout. `iorq` and `rd` (read) or `wr` (write) are high from the start of T2 to the end of T3's first half. A write drives data as in R6.
- R8: WAIT is sampled only at the edge between the halves of T2 (memory and fetch) or of TA and each TW (I/O). Each high sample adds one two-clock wait state, and WAIT at any other time has no effect.
- R9: `cyc_done` is high for exactly the last clock of a cycle (second half of T3, or of T4 for a fetch). `rdata` is valid in that clock for reads.
- R10: `busreq` is sampled only in the last clock of a cycle or while idle. When it is high, the next clock has:
  - `busack`=1 and `bus_drive`=0;
  - `addr_out`=0;
  - all strobes and `data_oe` low.
  A request that goes away before the last clock causes no grant.
- R11: The grant lasts while `busreq` is high. `busack` falls, and the bus is driven again, one clock after `busreq` is seen low.
- R12: After reset the sequencer is idle, with:
  - strobes, `data_oe`, `busack` and `cyc_done` low;
  - `bus_drive` high;
  - `addr_out` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two per T-state |
| rst | input | 1 | Asynchronous reset, active high |
| req_valid | input | 1 | Cycle request strobe |
| req_kind | input | 3 | Cycle kind code (R1) |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| wait_in | input | 1 | Wait request from memory or I/O |
| busreq | input | 1 | External bus request |
| data_in | input | 8 | Data bus input |
| addr_out | output | 16 | Address bus |
| data_out | output | 8 | Data bus output |
| data_oe | output | 1 | Data bus output enable |
| bus_drive | output | 1 | Address and control drivers enabled |
| mreq | output | 1 | Memory request strobe |
| iorq | output | 1 | I/O request strobe |
| rd | output | 1 | Read strobe |
| wr | output | 1 | Write strobe |
| m1 | output | 1 | Opcode fetch indicator |
| rfsh | output | 1 | Refresh indicator |
| busack | output | 1 | Bus grant |
| rdata | output | 8 | Captured read byte |
| cyc_done | output | 1 | Last clock of a machine cycle |

## Verification
The hardest situations to reach from the ports are the refresh wrap and a bus request that lands exactly on the last clock of a cycle.

The wrap is only visible after 128 fetches. The bench therefore runs a long chain of fetch cycles and predicts the refresh address of each one from its own count.

For bus requests, the bench indexes every clock of a cycle by its position. It can then raise and drop `busreq` at chosen positions: one request held into the last clock, and one pulse that ends mid-cycle. It also drives WAIT high in every clock that must not be sampled, so a misplaced sample shows up as a longer cycle.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

    typedef enum logic [2:0] {
        K_FETCH = 3'd0,
        K_MRD   = 3'd1,
        K_MWR   = 3'd2,
        K_IORD  = 3'd3,
        K_IOWR  = 3'd4
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_TA,
        ST_TW,
        ST_T3,
        ST_T4,
        ST_HOLD
    } tstate_e;

    typedef struct packed {
        logic mreq;
        logic iorq;
        logic rd;
        logic wr;
        logic m1;
        logic rfsh;
        logic dout_oe;
        logic rfsh_addr;
    } strobes_t;

    function automatic logic kind_legal(input logic [2:0] k);
        return k <= 3'd4;
    endfunction

    function automatic logic kind_is_io(input kind_e k);
        return (k == K_IORD) || (k == K_IOWR);
    endfunction

    function automatic logic kind_is_read(input kind_e k);
        return (k == K_MRD) || (k == K_IORD);
    endfunction

    function automatic logic kind_is_write(input kind_e k);
        return (k == K_MWR) || (k == K_IOWR);
    endfunction

endpackage

// File: rtl/bus_seq_rfsh.sv
module bus_seq_rfsh #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            count <= '0;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
    import bus_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [2:0] req_kind,
    input  logic       wait_in,
    input  logic       busreq,
    output tstate_e    state,
    output logic       half,
    output kind_e      kind,
    output logic       start,
    output logic       last,
    output logic       sample_data,
    output logic       fetch_end
);
    tstate_e state_q, state_d;
    logic    half_q, half_d;
    kind_e   kind_q, kind_d;
    logic    wait_q, wait_d;

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= ST_IDLE;
            half_q  <= 1'b0;
            kind_q  <= K_FETCH;
            wait_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            half_q  <= half_d;
            kind_q  <= kind_d;
            wait_q  <= wait_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        half_d  = ~half_q;
        kind_d  = kind_q;
        wait_d  = wait_q;
        start   = 1'b0;
        last    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                half_d = 1'b0;
                if (busreq) begin
                    state_d = ST_HOLD;
                end else if (req_valid && kind_legal(req_kind)) begin
                    state_d = ST_T1;
                    kind_d  = kind_e'(req_kind);
                    start   = 1'b1;
                end
            end
            ST_T1: begin
                if (half_q) state_d = ST_T2;
            end
            ST_T2: begin
                if (!half_q) begin
                    if (!kind_is_io(kind_q)) wait_d = wait_in;
                end else if (kind_is_io(kind_q)) begin
                    state_d = ST_TA;
                end else begin
                    state_d = wait_q ? ST_TW : ST_T3;
                end
            end
            ST_TA, ST_TW: begin
                if (!half_q) wait_d = wait_in;
                else         state_d = wait_q ? ST_TW : ST_T3;
            end
            ST_T3: begin
                if (half_q) begin
                    if (kind_q == K_FETCH) state_d = ST_T4;
                    else                   last = 1'b1;
                end
            end
            ST_T4: begin
                if (half_q) last = 1'b1;
            end
            ST_HOLD: begin
                half_d = 1'b0;
                if (!busreq) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (last) state_d = busreq ? ST_HOLD : ST_IDLE;
    end

    always_comb begin
        sample_data = ((kind_q == K_FETCH) && half_q
                       && ((state_q == ST_T2) || (state_q == ST_TW))
                       && (state_d == ST_T3))
                   || (kind_is_read(kind_q) && (state_q == ST_T3) && !half_q);
        fetch_end   = last && (kind_q == K_FETCH);
    end

    assign state = state_q;
    assign half  = half_q;
    assign kind  = kind_q;
endmodule

// File: rtl/bus_seq_drive.sv
module bus_seq_drive
    import bus_seq_pkg::*;
(
    input  tstate_e  st,
    input  logic     half,
    input  kind_e    kind,
    output strobes_t so
);
    logic t1b, t2, ta, tw, t3a, t3, t3b, t4, t4a;
    logic fetch, io, rdk, wrk, mem_span, io_span;

    always_comb begin
        t1b   = (st == ST_T1) && half;
        t2    = (st == ST_T2);
        ta    = (st == ST_TA);
        tw    = (st == ST_TW);
        t3    = (st == ST_T3);
        t3a   = t3 && !half;
        t3b   = t3 && half;
        t4    = (st == ST_T4);
        t4a   = t4 && !half;
        fetch = (kind == K_FETCH);
        io    = kind_is_io(kind);
        rdk   = kind_is_read(kind);
        wrk   = kind_is_write(kind);

        mem_span = t1b || t2 || tw || t3a;
        io_span  = t2 || ta || tw || t3a;

        so = '0;
        if (fetch) begin
            so.m1        = (st == ST_T1) || t2 || tw;
            so.rd        = t1b || t2 || tw;
            so.mreq      = t1b || t2 || tw || t3b || t4a;
            so.rfsh      = t3 || t4;
            so.rfsh_addr = t3 || t4;
        end else if (io) begin
            so.iorq    = io_span;
            so.rd      = rdk && io_span;
            so.wr      = wrk && io_span;
            so.dout_oe = wrk && (t1b || t2 || ta || tw || t3);
        end else begin
            so.mreq    = mem_span;
            so.rd      = rdk && mem_span;
            so.wr      = wrk && ((t2 && half) || tw || t3a);
            so.dout_oe = wrk && (t1b || t2 || tw || t3);
        end
    end
endmodule

// File: rtl/bus_seq.sv
module bus_seq
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int RFSH_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              wait_in,
    input  logic              busreq,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              bus_drive,
    output logic              mreq,
    output logic              iorq,
    output logic              rd,
    output logic              wr,
    output logic              m1,
    output logic              rfsh,
    output logic              busack,
    output logic [DATA_W-1:0] rdata,
    output logic              cyc_done
);
    localparam int PAD_W = ADDR_W - RFSH_W;

    tstate_e           state;
    logic              half;
    kind_e             kind;
    logic              start, last, sample_data, fetch_end;
    strobes_t          so;
    logic [RFSH_W-1:0] rcount;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    bus_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_kind    (req_kind),
        .wait_in     (wait_in),
        .busreq      (busreq),
        .state       (state),
        .half        (half),
        .kind        (kind),
        .start       (start),
        .last        (last),
        .sample_data (sample_data),
        .fetch_end   (fetch_end)
    );

    bus_seq_drive u_drive (
        .st   (state),
        .half (half),
        .kind (kind),
        .so   (so)
    );

    bus_seq_rfsh #(.W(RFSH_W)) u_rfsh (
        .clk   (clk),
        .rst   (rst),
        .step  (fetch_end),
        .count (rcount)
    );

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (start) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (sample_data) rdata_q <= data_in;
        end
    end

    // output process
    always_comb begin
        bus_drive = (state != ST_HOLD);
        busack    = (state == ST_HOLD);
        if (!bus_drive)        addr_out = '0;
        else if (so.rfsh_addr) addr_out = {{PAD_W{1'b0}}, rcount};
        else                   addr_out = addr_q;
        data_oe  = bus_drive && so.dout_oe;
        data_out = data_oe ? wdata_q : '0;
        mreq     = bus_drive && so.mreq;
        iorq     = bus_drive && so.iorq;
        rd       = bus_drive && so.rd;
        wr       = bus_drive && so.wr;
        m1       = bus_drive && so.m1;
        rfsh     = bus_drive && so.rfsh;
        rdata    = rdata_q;
        cyc_done = last;
    end
endmodule

// File: rtl/bus_seq_chk.sv
module bus_seq_chk (
    input logic clk,
    input logic rst,
    input logic mreq,
    input logic iorq,
    input logic rd,
    input logic wr,
    input logic rfsh,
    input logic data_oe,
    input logic busreq,
    input logic busack,
    input logic cyc_done
);
    // R7
    mreq_iorq_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mreq && iorq));

    // R6
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd && wr));

    // R3
    rfsh_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        rfsh |-> !rd);

    // R10
    grant_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        busack |-> !(mreq || iorq || rd || wr || data_oe));

    // R10
    grant_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_done && busreq) |=> busack);

    // R11
    grant_release_chk: assert property (@(posedge clk) disable iff (rst)
        (busack && !busreq) |=> !busack);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_done |=> !cyc_done);
endmodule

bind bus_seq bus_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mreq     (mreq),
    .iorq     (iorq),
    .rd       (rd),
    .wr       (wr),
    .rfsh     (rfsh),
    .data_oe  (data_oe),
    .busreq   (busreq),
    .busack   (busack),
    .cyc_done (cyc_done)
);

// File: tb/bus_seq_test.sv
`timescale 1ns/1ps
module bus_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        wait_in = 1'b0;
    logic        busreq = 1'b0;
    logic [7:0]  data_in = 8'h0;
    logic [15:0] addr_out;
    logic [7:0]  data_out;
    logic        data_oe, bus_drive, mreq, iorq, rd, wr, m1, rfsh, busack, cyc_done;
    logic [7:0]  rdata;

    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;
    logic [6:0] rexp = 7'd0;

    always #10 clk = ~clk;

    bus_seq uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .wait_in(wait_in),
        .busreq(busreq), .data_in(data_in), .addr_out(addr_out),
        .data_out(data_out), .data_oe(data_oe), .bus_drive(bus_drive),
        .mreq(mreq), .iorq(iorq), .rd(rd), .wr(wr), .m1(m1), .rfsh(rfsh),
        .busack(busack), .rdata(rdata), .cyc_done(cyc_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] ctl_now();
        return {mreq, iorq, rd, wr, m1, rfsh, data_oe, cyc_done, busack, bus_drive};
    endfunction

    task automatic chk_idle(input string tag);
        chk(tag, {22'd0, ctl_now()}, {22'd0, 10'b0000000001});
    endtask

    // t codes: 1=T1 2=T2 3=TA 4=TW 5=T3 6=T4
    function automatic logic [9:0] expect_ctl(input int k, input int t, input bit h);
        bit e_mreq, e_iorq, e_rd, e_wr, e_m1, e_rf, e_oe, e_done;
        bit span;
        e_mreq = 0; e_iorq = 0; e_rd = 0; e_wr = 0; e_m1 = 0; e_rf = 0; e_oe = 0;
        if (k == 0) begin
            e_m1   = (t == 1) || (t == 2) || (t == 4);
            e_rd   = (t == 1 && h) || (t == 2) || (t == 4);
            e_mreq = e_rd || (t == 5 && h) || (t == 6 && !h);
            e_rf   = (t == 5) || (t == 6);
        end else if (k <= 2) begin
            span   = (t == 1 && h) || (t == 2) || (t == 4) || (t == 5 && !h);
            e_mreq = span;
            e_rd   = (k == 1) && span;
            e_wr   = (k == 2) && ((t == 2 && h) || (t == 4) || (t == 5 && !h));
            e_oe   = (k == 2) && ((t == 1 && h) || (t == 2) || (t == 4) || (t == 5));
        end else begin
            span   = (t == 2) || (t == 3) || (t == 4) || (t == 5 && !h);
            e_iorq = span;
            e_rd   = (k == 3) && span;
            e_wr   = (k == 4) && span;
            e_oe   = (k == 4) && ((t == 1 && h) || (t >= 2 && t <= 5));
        end
        e_done = h && (((k == 0) && (t == 6)) || ((k != 0) && (t == 5)));
        return {e_mreq, e_iorq, e_rd, e_wr, e_m1, e_rf, e_oe, e_done, 1'b0, 1'b1};
    endfunction

    // Runs one machine cycle from an idle clock; returns at the clock after done.
    task automatic do_cycle(input int k, input logic [15:0] a, input logic [7:0] wd,
                            input logic [7:0] rdv, input int nw, input int noise_at,
                            input int brq_on, input int brq_off);
        int    seq[12];
        int    n;
        int    w_used;
        int    t;
        bit    h;
        bit    slot, cap;
        string tg;
        logic [15:0] ea;
        n = 0;
        seq[n] = 1; n = n + 1;
        seq[n] = 2; n = n + 1;
        if (k >= 3) begin seq[n] = 3; n = n + 1; end
        for (int i = 0; i < nw; i++) begin seq[n] = 4; n = n + 1; end
        seq[n] = 5; n = n + 1;
        if (k == 0) begin seq[n] = 6; n = n + 1; end
        case (k)
            0: tg = "R2 R3 fetch";
            1: tg = "R5 mem read";
            2: tg = "R6 mem write";
            default: tg = "R7 io";
        endcase
        if (nw > 0) tg = {tg, " R8 waits"};
        req_valid = 1'b1; req_kind = k[2:0]; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        w_used = 0;
        for (int s = 0; s < 2 * n; s++) begin
            t = seq[s / 2];
            h = (s % 2) == 1;
            chk({tg, " strobes R9"}, {22'd0, ctl_now()}, {22'd0, expect_ctl(k, t, h)});
            ea = (k == 0 && t >= 5) ? {9'd0, rexp} : a;
            chk({tg, " address R3 R4"}, {16'd0, addr_out}, {16'd0, ea});
            if (k == 2 || k == 4)
                if (expect_ctl(k, t, h)[3]) chk({tg, " write data R6"}, {24'd0, data_out}, {24'd0, wd});
            if (h && ((k == 0 && t == 6) || ((k == 1 || k == 3) && t == 5)))
                chk({tg, " read data R9"}, {24'd0, rdata}, {24'd0, rdv});
            slot = !h && (((k < 3) && (t == 2 || t == 4)) || ((k >= 3) && (t == 3 || t == 4)));
            if (slot) begin
                wait_in = (w_used < nw);
                if (w_used < nw) w_used++;
            end else begin
                wait_in = 1'b1;
            end
            if (k == 0) cap = (s + 1 < 2 * n) && (seq[(s + 1) / 2] == 5) && ((s + 1) % 2 == 0);
            else        cap = (k == 1 || k == 3) && (t == 5) && !h;
            data_in   = cap ? rdv : ~rdv;
            req_valid = (s == noise_at);
            req_kind  = 3'd2;
            if (s == brq_on)  busreq = 1'b1;
            if (s == brq_off) busreq = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        wait_in = 1'b0;
        if (k == 0) rexp = rexp + 7'd1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk_idle("R12 reset strobes");
        chk("R12 reset address", {16'd0, addr_out}, 32'd0);

        // sweep kinds and wait counts
        for (int k = 0; k < 5; k++)
            for (int w = 0; w < 4; w++)
                do_cycle(k, 16'h1000 * k + 16'h0111 * w + 16'h00A5,
                         8'h3C ^ 8'(k * 16 + w), 8'hC3 + 8'(k * 7 + w), w, -1, -1, -1);

        // R4 refresh wrap over 130 fetches
        for (int i = 0; i < 130; i++)
            do_cycle(0, 16'(i * 3), 8'h00, 8'(i), i % 2, -1, -1, -1);

        // R1 request during busy cycle ignored
        do_cycle(0, 16'h7777, 8'h00, 8'h11, 0, 3, -1, -1);
        chk_idle("R1 busy request ignored a");
        @(negedge clk);
        chk_idle("R1 busy request ignored b");

        // R1 illegal kind ignored
        req_valid = 1'b1; req_kind = 3'd7; req_addr = 16'hBEEF;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk_idle("R1 illegal kind");
            @(negedge clk);
        end

        // R10 busreq pulse ending mid-cycle: no grant
        do_cycle(2, 16'h2468, 8'h99, 8'h00, 0, -1, 2, 4);
        chk("R10 mid-cycle request no grant", {31'd0, busack}, 32'd0);

        // R10 R11 busreq held to end of cycle
        do_cycle(1, 16'h4242, 8'h00, 8'h5A, 1, -1, 1, -1);
        chk("R10 grant after last clock", {31'd0, busack}, 32'd1);
        chk("R10 bus released", {31'd0, bus_drive}, 32'd0);
        chk("R10 address released", {16'd0, addr_out}, 32'd0);
        for (int i = 0; i < 5; i++) begin
            req_valid = 1'b1; req_kind = 3'd0;
            @(negedge clk);
            chk("R11 grant held", {22'd0, ctl_now()}, {22'd0, 10'b0000000010});
        end
        req_valid = 1'b0;
        busreq = 1'b0;
        @(negedge clk);
        chk("R11 grant dropped", {30'd0, busack, bus_drive}, 32'd1);
        @(negedge clk);
        chk_idle("R1 no cycle from grant requests");

        // R10 R11 busreq while idle
        busreq = 1'b1;
        @(negedge clk);
        chk("R10 idle grant", {31'd0, busack}, 32'd1);
        busreq = 1'b0;
        @(negedge clk);
        chk("R11 idle release", {31'd0, busack}, 32'd0);

        // a fetch after grant still uses the running refresh count
        do_cycle(0, 16'hFFFF, 8'h00, 8'hE7, 2, -1, -1, -1);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule